// File: doc/BRIEF.md
# Virtual Plane Routing Table

This block sits inside a switch that carries traffic for several root complexes at once. Each root complex owns its own plane, and each plane has its own upstream and downstream address windows. For every packet the block picks an egress port. It looks the packet up in a small table of routing entries, keyed on the packet's plane number together with either its address or its requester ID. The plane number travels beside the packet at the link layer, so only the fields the lookup needs are presented here.

Ports that face components unaware of planes are bound, one each, to a single plane. A packet arriving on such a port carries no plane number, so the block substitutes the port's bound plane. When the chosen egress port faces such a component, the block raises a flag that tells the egress path to remove the plane tag. Plane 0 is kept for in-band management and can never be bound to a legacy port.

Management logic programs routing entries and port bindings through two simple write ports. A lookup presented in one cycle is answered in the next.

Top module: `vplane_router`

## Requirements
- R1: After reset every routing entry is empty and every port is plane-aware. All response outputs are 0, and any lookup misses.
- R2: A response appears exactly one cycle after its request, with rsp_valid equal to the previous cycle's req_valid. When no request was made, every response field is 0.
- R3: A downstream request (req_up=0) matches a valid entry of equal plane when base <= address <= limit, with both bounds inclusive.
- R4: An upstream request (req_up=1) matches an entry whose ID-match bit is set only on an equal requester ID, and the address is ignored. When that bit is clear, it matches on the address range.
- R5: When several entries match, the one with the lowest index supplies the egress port.
- R6: A miss gives rsp_ur=1, rsp_hit=0, rsp_port=0 and rsp_strip=0. A hit gives rsp_hit=1 and rsp_ur=0.
- R7: A request arriving on a port bound as legacy uses that port's bound plane, and req_plane is ignored. A request from a plane-aware port, or from a port index of NUM_PORTS or more, uses req_plane. In both cases rsp_plane reports the plane that was used.
- R8: rsp_strip is 1 exactly when the request hits and its egress port is bound as legacy.
- R9: A binding write with legacy=1 and plane 0 is ignored, and so is a binding write to a port index of NUM_PORTS or more. A write with legacy=0 returns the port to plane-aware.
- R10: A table write with valid=1 and an egress port of NUM_PORTS or more is ignored, and the entry keeps its old contents.
- R11: Table and binding writes take effect for lookups from the next cycle onward. A lookup in the same cycle as a write sees the old contents.
- R12: A table write with valid=0 removes the entry, so later lookups fall through to higher-index entries or miss.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| tbl_wr_en | input | 1 | Routing entry write strobe |
| tbl_wr_idx | input | IDX_W | Entry index to write |
| tbl_wr_valid | input | 1 | Entry valid (0 removes the entry) |
| tbl_wr_plane | input | PLANE_W | Entry plane number |
| tbl_wr_rid_en | input | 1 | Upstream requests match on requester ID |
| tbl_wr_rid | input | RID_W | Requester ID (bus/device/function) |
| tbl_wr_port | input | PORT_W | Egress port |
| tbl_wr_base | input | ADDR_W | Inclusive lower address bound |
| tbl_wr_limit | input | ADDR_W | Inclusive upper address bound |
| bind_wr_en | input | 1 | Port binding write strobe |
| bind_wr_port | input | PORT_W | Port being bound |
| bind_wr_legacy | input | 1 | 1 binds the port as legacy, 0 makes it plane-aware |
| bind_wr_plane | input | PLANE_W | Plane for a legacy binding |
| req_valid | input | 1 | Lookup request |
| req_in_port | input | PORT_W | Ingress port of the packet |
| req_plane | input | PLANE_W | Plane tag carried by the packet |
| req_rid | input | RID_W | Requester ID of the packet |
| req_addr | input | ADDR_W | Packet address |
| req_up | input | 1 | 1 for upstream, 0 for downstream |
| rsp_valid | output | 1 | Response valid |
| rsp_hit | output | 1 | An entry matched |
| rsp_ur | output | 1 | Miss: unsupported request |
| rsp_port | output | PORT_W | Chosen egress port |
| rsp_plane | output | PLANE_W | Plane used for the lookup |
| rsp_strip | output | 1 | Remove plane tag on egress |

## Verification
The assertions rely on the reset holding the table and the bindings empty. They also take every write port value that reaches storage to have passed the range and plane-0 filters. Beyond that they assume nothing about the inputs. Every port index up to the full width of the port field is legal stimulus, and the bench deliberately drives out-of-range ports, plane-0 legacy binds and overlapping entries. A behavioural model predicts every response, and each cycle the bench compares the block against it through directed corner cases and a long stretch of random writes and lookups.

// File: rtl/vpr_pkg.sv
package vpr_pkg;
  localparam int DEF_ENTRIES = 16;
  localparam int DEF_PLANE_W = 4;
  localparam int DEF_RID_W   = 16;
  localparam int DEF_ADDR_W  = 32;
  localparam int DEF_PORTS   = 6;

  typedef enum logic {
    DIR_DOWN = 1'b0,
    DIR_UP   = 1'b1
  } dir_e;
endpackage

// File: rtl/vpr_entry_table.sv
module vpr_entry_table #(
  parameter int N         = vpr_pkg::DEF_ENTRIES,
  parameter int PLANE_W   = vpr_pkg::DEF_PLANE_W,
  parameter int RID_W     = vpr_pkg::DEF_RID_W,
  parameter int ADDR_W    = vpr_pkg::DEF_ADDR_W,
  parameter int NUM_PORTS = vpr_pkg::DEF_PORTS,
  parameter int PORT_W    = (NUM_PORTS > 1) ? $clog2(NUM_PORTS) : 1,
  parameter int IDX_W     = (N > 1) ? $clog2(N) : 1
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                wr_en,
  input  logic [IDX_W-1:0]    wr_idx,
  input  logic                wr_valid,
  input  logic [PLANE_W-1:0]  wr_plane,
  input  logic                wr_rid_en,
  input  logic [RID_W-1:0]    wr_rid,
  input  logic [PORT_W-1:0]   wr_port,
  input  logic [ADDR_W-1:0]   wr_base,
  input  logic [ADDR_W-1:0]   wr_limit,
  input  logic [PLANE_W-1:0]  lk_plane,
  input  logic [RID_W-1:0]    lk_rid,
  input  logic [ADDR_W-1:0]   lk_addr,
  input  vpr_pkg::dir_e       lk_dir,
  output logic [N-1:0]        hit_vec,
  output logic [N*PORT_W-1:0] port_flat
);
  localparam logic [PORT_W:0] PORT_LIM = (PORT_W+1)'(NUM_PORTS);

  logic wr_port_ok;
  logic wr_accept;

  always_comb begin
    wr_port_ok = ({1'b0, wr_port} < PORT_LIM);
    wr_accept  = wr_en && (!wr_valid || wr_port_ok);
  end

  for (genvar g = 0; g < N; g++) begin : g_ent
    logic               v_q, v_d;
    logic [PLANE_W-1:0] plane_q, plane_d;
    logic               rid_en_q, rid_en_d;
    logic [RID_W-1:0]   rid_q, rid_d;
    logic [PORT_W-1:0]  port_q, port_d;
    logic [ADDR_W-1:0]  base_q, base_d;
    logic [ADDR_W-1:0]  limit_q, limit_d;
    logic               ld;
    logic               plane_eq, range_ok, rid_ok;

    // next-state
    always_comb begin
      ld       = wr_accept && (wr_idx == IDX_W'(g));
      v_d      = wr_valid;
      plane_d  = wr_plane;
      rid_en_d = wr_rid_en;
      rid_d    = wr_rid;
      port_d   = wr_port;
      base_d   = wr_base;
      limit_d  = wr_limit;
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        v_q      <= 1'b0;
        plane_q  <= '0;
        rid_en_q <= 1'b0;
        rid_q    <= '0;
        port_q   <= '0;
        base_q   <= '0;
        limit_q  <= '0;
      end else if (ld) begin
        v_q      <= v_d;
        plane_q  <= plane_d;
        rid_en_q <= rid_en_d;
        rid_q    <= rid_d;
        port_q   <= port_d;
        base_q   <= base_d;
        limit_q  <= limit_d;
      end
    end

    // match logic
    always_comb begin
      plane_eq   = (plane_q == lk_plane);
      range_ok   = (lk_addr >= base_q) && (lk_addr <= limit_q);
      rid_ok     = (rid_q == lk_rid);
      hit_vec[g] = v_q && plane_eq &&
                   (((lk_dir == vpr_pkg::DIR_UP) && rid_en_q) ? rid_ok : range_ok);
    end

    assign port_flat[g*PORT_W +: PORT_W] = port_q;

    // R10
    entry_port_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
      v_q |-> ({1'b0, port_q} < PORT_LIM));
  end
endmodule

// File: rtl/vpr_port_bind.sv
module vpr_port_bind #(
  parameter int NUM_PORTS = vpr_pkg::DEF_PORTS,
  parameter int PLANE_W   = vpr_pkg::DEF_PLANE_W,
  parameter int PORT_W    = (NUM_PORTS > 1) ? $clog2(NUM_PORTS) : 1
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               wr_en,
  input  logic [PORT_W-1:0]  wr_port,
  input  logic               wr_legacy,
  input  logic [PLANE_W-1:0] wr_plane,
  input  logic [PORT_W-1:0]  in_port,
  output logic               in_legacy,
  output logic [PLANE_W-1:0] in_plane,
  input  logic [PORT_W-1:0]  eg_port,
  output logic               eg_legacy
);
  localparam logic [PORT_W:0] PORT_LIM = (PORT_W+1)'(NUM_PORTS);

  logic                         accept;
  logic [NUM_PORTS-1:0]         leg_vec;
  logic [NUM_PORTS*PLANE_W-1:0] plane_vec;

  always_comb begin
    accept = wr_en && ({1'b0, wr_port} < PORT_LIM) &&
             !(wr_legacy && (wr_plane == '0));
  end

  for (genvar g = 0; g < NUM_PORTS; g++) begin : g_port
    logic               leg_q, leg_d;
    logic [PLANE_W-1:0] plane_q, plane_d;
    logic               ld;

    always_comb begin
      ld      = accept && (wr_port == PORT_W'(g));
      leg_d   = wr_legacy;
      plane_d = wr_legacy ? wr_plane : '0;
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        leg_q   <= 1'b0;
        plane_q <= '0;
      end else if (ld) begin
        leg_q   <= leg_d;
        plane_q <= plane_d;
      end
    end

    assign leg_vec[g]                     = leg_q;
    assign plane_vec[g*PLANE_W +: PLANE_W] = plane_q;

    // R9
    no_plane0_bind_chk: assert property (@(posedge clk) disable iff (!rst_n)
      leg_q |-> (plane_q != '0));
  end

  always_comb begin
    in_legacy = 1'b0;
    in_plane  = '0;
    eg_legacy = 1'b0;
    for (int i = 0; i < NUM_PORTS; i++) begin
      if (in_port == PORT_W'(i)) begin
        in_legacy = leg_vec[i];
        in_plane  = plane_vec[i*PLANE_W +: PLANE_W];
      end
      if (eg_port == PORT_W'(i)) begin
        eg_legacy = leg_vec[i];
      end
    end
  end
endmodule

// File: rtl/vpr_prio_pick.sv
module vpr_prio_pick #(
  parameter int N      = vpr_pkg::DEF_ENTRIES,
  parameter int PORT_W = 3
) (
  input  logic [N-1:0]        hit_vec,
  input  logic [N*PORT_W-1:0] port_flat,
  output logic                any_hit,
  output logic [PORT_W-1:0]   sel_port
);
  always_comb begin
    any_hit  = 1'b0;
    sel_port = '0;
    for (int i = N - 1; i >= 0; i--) begin
      if (hit_vec[i]) begin
        any_hit  = 1'b1;
        sel_port = port_flat[i*PORT_W +: PORT_W];
      end
    end
  end
endmodule

// File: rtl/vplane_router.sv
module vplane_router #(
  parameter int N         = vpr_pkg::DEF_ENTRIES,
  parameter int PLANE_W   = vpr_pkg::DEF_PLANE_W,
  parameter int RID_W     = vpr_pkg::DEF_RID_W,
  parameter int ADDR_W    = vpr_pkg::DEF_ADDR_W,
  parameter int NUM_PORTS = vpr_pkg::DEF_PORTS,
  localparam int PORT_W   = (NUM_PORTS > 1) ? $clog2(NUM_PORTS) : 1,
  localparam int IDX_W    = (N > 1) ? $clog2(N) : 1
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               tbl_wr_en,
  input  logic [IDX_W-1:0]   tbl_wr_idx,
  input  logic               tbl_wr_valid,
  input  logic [PLANE_W-1:0] tbl_wr_plane,
  input  logic               tbl_wr_rid_en,
  input  logic [RID_W-1:0]   tbl_wr_rid,
  input  logic [PORT_W-1:0]  tbl_wr_port,
  input  logic [ADDR_W-1:0]  tbl_wr_base,
  input  logic [ADDR_W-1:0]  tbl_wr_limit,
  input  logic               bind_wr_en,
  input  logic [PORT_W-1:0]  bind_wr_port,
  input  logic               bind_wr_legacy,
  input  logic [PLANE_W-1:0] bind_wr_plane,
  input  logic               req_valid,
  input  logic [PORT_W-1:0]  req_in_port,
  input  logic [PLANE_W-1:0] req_plane,
  input  logic [RID_W-1:0]   req_rid,
  input  logic [ADDR_W-1:0]  req_addr,
  input  logic               req_up,
  output logic               rsp_valid,
  output logic               rsp_hit,
  output logic               rsp_ur,
  output logic [PORT_W-1:0]  rsp_port,
  output logic [PLANE_W-1:0] rsp_plane,
  output logic               rsp_strip
);
  logic [N-1:0]        hit_vec;
  logic [N*PORT_W-1:0] port_flat;
  logic                any_hit;
  logic [PORT_W-1:0]   sel_port;
  logic                in_legacy;
  logic [PLANE_W-1:0]  in_plane;
  logic                eg_legacy;
  logic [PLANE_W-1:0]  eff_plane;
  vpr_pkg::dir_e       lk_dir;

  logic               v_d, hit_d, ur_d, strip_d;
  logic [PORT_W-1:0]  port_d;
  logic [PLANE_W-1:0] plane_d;

  always_comb begin
    eff_plane = in_legacy ? in_plane : req_plane;
    lk_dir    = req_up ? vpr_pkg::DIR_UP : vpr_pkg::DIR_DOWN;
  end

  vpr_port_bind #(
    .NUM_PORTS(NUM_PORTS), .PLANE_W(PLANE_W), .PORT_W(PORT_W)
  ) bind_i (
    .clk(clk), .rst_n(rst_n),
    .wr_en(bind_wr_en), .wr_port(bind_wr_port),
    .wr_legacy(bind_wr_legacy), .wr_plane(bind_wr_plane),
    .in_port(req_in_port), .in_legacy(in_legacy), .in_plane(in_plane),
    .eg_port(sel_port), .eg_legacy(eg_legacy)
  );

  vpr_entry_table #(
    .N(N), .PLANE_W(PLANE_W), .RID_W(RID_W), .ADDR_W(ADDR_W),
    .NUM_PORTS(NUM_PORTS), .PORT_W(PORT_W), .IDX_W(IDX_W)
  ) table_i (
    .clk(clk), .rst_n(rst_n),
    .wr_en(tbl_wr_en), .wr_idx(tbl_wr_idx), .wr_valid(tbl_wr_valid),
    .wr_plane(tbl_wr_plane), .wr_rid_en(tbl_wr_rid_en), .wr_rid(tbl_wr_rid),
    .wr_port(tbl_wr_port), .wr_base(tbl_wr_base), .wr_limit(tbl_wr_limit),
    .lk_plane(eff_plane), .lk_rid(req_rid), .lk_addr(req_addr), .lk_dir(lk_dir),
    .hit_vec(hit_vec), .port_flat(port_flat)
  );

  vpr_prio_pick #(.N(N), .PORT_W(PORT_W)) pick_i (
    .hit_vec(hit_vec), .port_flat(port_flat),
    .any_hit(any_hit), .sel_port(sel_port)
  );

  // next-state of the response stage
  always_comb begin
    v_d     = 1'b0;
    hit_d   = 1'b0;
    ur_d    = 1'b0;
    port_d  = '0;
    plane_d = '0;
    strip_d = 1'b0;
    if (req_valid) begin
      v_d     = 1'b1;
      hit_d   = any_hit;
      ur_d    = !any_hit;
      port_d  = any_hit ? sel_port : '0;
      plane_d = eff_plane;
      strip_d = any_hit && eg_legacy;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rsp_valid <= 1'b0;
      rsp_hit   <= 1'b0;
      rsp_ur    <= 1'b0;
      rsp_port  <= '0;
      rsp_plane <= '0;
      rsp_strip <= 1'b0;
    end else begin
      rsp_valid <= v_d;
      rsp_hit   <= hit_d;
      rsp_ur    <= ur_d;
      rsp_port  <= port_d;
      rsp_plane <= plane_d;
      rsp_strip <= strip_d;
    end
  end

  // R2
  rsp_follows_req_chk: assert property (@(posedge clk) disable iff (!rst_n)
    req_valid |=> rsp_valid);
  // R2
  no_spurious_rsp_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !req_valid |=> (!rsp_valid && !rsp_hit && !rsp_ur && !rsp_strip));
  // R6
  hit_ur_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid |-> (rsp_hit != rsp_ur));
  // R6
  miss_clean_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_ur |-> (rsp_port == '0 && !rsp_strip));
  // R8
  strip_needs_hit_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_strip |-> rsp_hit);
  // R7
  aware_plane_pass_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && !in_legacy) |=> (rsp_plane == $past(req_plane)));
  // R5
  pick_agrees_chk: assert property (@(posedge clk) disable iff (!rst_n)
    any_hit == (|hit_vec));
endmodule

// File: tb/vplane_router_tb_top.sv
module vplane_router_tb_top;
  localparam int CLK_PERIOD = 10;
  localparam int N  = 16;
  localparam int PW = 4;
  localparam int RW = 16;
  localparam int AW = 32;
  localparam int NP = 6;
  localparam int TW = 3;
  localparam int IW = 4;

  logic clk, rst_n;
  logic          tbl_wr_en, tbl_wr_valid, tbl_wr_rid_en;
  logic [IW-1:0] tbl_wr_idx;
  logic [PW-1:0] tbl_wr_plane;
  logic [RW-1:0] tbl_wr_rid;
  logic [TW-1:0] tbl_wr_port;
  logic [AW-1:0] tbl_wr_base, tbl_wr_limit;
  logic          bind_wr_en, bind_wr_legacy;
  logic [TW-1:0] bind_wr_port;
  logic [PW-1:0] bind_wr_plane;
  logic          req_valid, req_up;
  logic [TW-1:0] req_in_port;
  logic [PW-1:0] req_plane;
  logic [RW-1:0] req_rid;
  logic [AW-1:0] req_addr;
  logic          rsp_valid, rsp_hit, rsp_ur, rsp_strip;
  logic [TW-1:0] rsp_port;
  logic [PW-1:0] rsp_plane;

  vplane_router dut_i (.*);

  initial clk = 1'b0;
  always #(CLK_PERIOD/2) clk = ~clk;

  int checks = 0;
  int fails  = 0;

  // reference model state
  bit      m_v[N];
  int      m_plane[N];
  bit      m_rid_en[N];
  int      m_rid[N];
  int      m_port[N];
  longint  m_base[N];
  longint  m_limit[N];
  bit      m_leg[NP];
  int      m_bplane[NP];

  bit e_v, e_hit, e_ur, e_strip;
  int e_port, e_plane;

  task automatic idle_inputs();
    tbl_wr_en = 0; tbl_wr_idx = '0; tbl_wr_valid = 0; tbl_wr_plane = '0;
    tbl_wr_rid_en = 0; tbl_wr_rid = '0; tbl_wr_port = '0;
    tbl_wr_base = '0; tbl_wr_limit = '0;
    bind_wr_en = 0; bind_wr_port = '0; bind_wr_legacy = 0; bind_wr_plane = '0;
    req_valid = 0; req_in_port = '0; req_plane = '0; req_rid = '0;
    req_addr = '0; req_up = 0;
  endtask

  task automatic set_req(int port, int plane, int rid, longint addr, bit up);
    req_valid = 1; req_in_port = TW'(port); req_plane = PW'(plane);
    req_rid = RW'(rid); req_addr = AW'(addr); req_up = up;
  endtask

  task automatic set_tbl(int idx, bit valid, int plane, bit rid_en, int rid,
                         int port, longint base, longint limit);
    tbl_wr_en = 1; tbl_wr_idx = IW'(idx); tbl_wr_valid = valid;
    tbl_wr_plane = PW'(plane); tbl_wr_rid_en = rid_en; tbl_wr_rid = RW'(rid);
    tbl_wr_port = TW'(port); tbl_wr_base = AW'(base); tbl_wr_limit = AW'(limit);
  endtask

  task automatic set_bind(int port, bit leg, int plane);
    bind_wr_en = 1; bind_wr_port = TW'(port); bind_wr_legacy = leg;
    bind_wr_plane = PW'(plane);
  endtask

  // model: lookup against current state, then apply writes
  task automatic model_cycle();
    int  eff;
    bit  found;
    int  ip;
    e_v = 0; e_hit = 0; e_ur = 0; e_strip = 0; e_port = 0; e_plane = 0;
    if (req_valid) begin
      ip  = int'(req_in_port);
      eff = (ip < NP && m_leg[ip]) ? m_bplane[ip] : int'(req_plane);
      found = 0;
      for (int i = 0; i < N && !found; i++) begin
        bit ok;
        if (!m_v[i] || m_plane[i] != eff) continue;
        if (req_up && m_rid_en[i]) ok = (m_rid[i] == int'(req_rid));
        else ok = (longint'(req_addr) >= m_base[i]) && (longint'(req_addr) <= m_limit[i]);
        if (ok) begin found = 1; e_port = m_port[i]; end
      end
      e_v = 1; e_hit = found; e_ur = !found; e_plane = eff;
      e_strip = found && m_leg[e_port];
    end
    if (tbl_wr_en && (!tbl_wr_valid || int'(tbl_wr_port) < NP)) begin
      int k = int'(tbl_wr_idx);
      m_v[k] = tbl_wr_valid; m_plane[k] = int'(tbl_wr_plane);
      m_rid_en[k] = tbl_wr_rid_en; m_rid[k] = int'(tbl_wr_rid);
      m_port[k] = int'(tbl_wr_port);
      m_base[k] = longint'(tbl_wr_base); m_limit[k] = longint'(tbl_wr_limit);
    end
    if (bind_wr_en && int'(bind_wr_port) < NP &&
        !(bind_wr_legacy && bind_wr_plane == '0)) begin
      m_leg[int'(bind_wr_port)] = bind_wr_legacy;
      m_bplane[int'(bind_wr_port)] = bind_wr_legacy ? int'(bind_wr_plane) : 0;
    end
  endtask

  task automatic compare(string tag);
    checks++;
    if (rsp_valid !== e_v || rsp_hit !== e_hit || rsp_ur !== e_ur ||
        int'(rsp_port) != e_port || int'(rsp_plane) != e_plane ||
        rsp_strip !== e_strip) begin
      fails++;
      $display("FAIL %s: actual v=%0d hit=%0d ur=%0d port=%0d plane=%0d strip=%0d expected v=%0d hit=%0d ur=%0d port=%0d plane=%0d strip=%0d",
               tag, rsp_valid, rsp_hit, rsp_ur, rsp_port, rsp_plane, rsp_strip,
               e_v, e_hit, e_ur, e_port, e_plane, e_strip);
    end
  endtask

  // called just after a falling edge with inputs set
  task automatic step(string tag);
    model_cycle();
    @(posedge clk);
    @(negedge clk);
    compare(tag);
    idle_inputs();
  endtask

  task automatic finish_run();
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  endtask

  initial begin
    #(CLK_PERIOD * 150000);
    fails++;
    $display("FAIL R2: watchdog expired, actual=running expected=finished");
    finish_run();
  end

  initial begin
    idle_inputs();
    for (int i = 0; i < N; i++) begin
      m_v[i] = 0; m_plane[i] = 0; m_rid_en[i] = 0; m_rid[i] = 0;
      m_port[i] = 0; m_base[i] = 0; m_limit[i] = 0;
    end
    for (int p = 0; p < NP; p++) begin m_leg[p] = 0; m_bplane[p] = 0; end
    rst_n = 0;
    repeat (3) @(negedge clk);
    e_v = 0; e_hit = 0; e_ur = 0; e_strip = 0; e_port = 0; e_plane = 0;
    compare("R1 reset outputs");
    rst_n = 1;

    // R1: empty table misses
    set_req(0, 2, 0, 'h1000, 0); step("R1 empty miss");
    // R11: write and lookup in the same cycle see old contents, then new
    set_tbl(0, 1, 2, 0, 0, 1, 'h1000, 'h1FFF);
    set_req(0, 2, 0, 'h1000, 0); step("R11 same-cycle write");
    set_req(0, 2, 0, 'h1000, 0); step("R11 next-cycle visible");
    set_tbl(1, 1, 2, 1, 'h0108, 2, 'h8000, 'h8FFF); step("R2 idle");
    set_tbl(2, 1, 2, 0, 0, 5, 'h0000, 'hFFFF);      step("R2 idle");
    set_tbl(3, 1, 3, 0, 0, 4, 'h1000, 'h1FFF);      step("R2 idle");
    // R3 boundaries and R5 priority
    set_req(0, 2, 0, 'h1000, 0); step("R3 low bound");
    set_req(0, 2, 0, 'h1FFF, 0); step("R3 high bound");
    set_req(0, 2, 0, 'h0FFF, 0); step("R5 fall to entry 2");
    set_req(0, 2, 0, 'h10000, 0); step("R6 miss past range");
    set_req(0, 3, 0, 'h1800, 0); step("R3 plane 3");
    set_req(0, 7, 0, 'h1800, 0); step("R6 unknown plane");
    set_req(0, 2, 0, 'h8000, 0); step("R5 downstream entry 1");
    // R4 upstream requester ID matching
    set_req(0, 2, 'h0108, 'h0, 1); step("R4 rid match");
    set_req(0, 2, 'h0109, 'h8000, 1); step("R4 rid mismatch ignores addr");
    set_req(0, 2, 'h0109, 'h1800, 1); step("R4 no rid bit uses addr");
    // R7 legacy ingress
    set_bind(3, 1, 3); step("R2 idle");
    set_req(3, 2, 0, 'h1000, 0); step("R7 legacy plane used");
    set_req(2, 3, 0, 'h1000, 0); step("R7 aware plane used");
    set_req(7, 2, 0, 'h1000, 0); step("R7 out-of-range ingress aware");
    // R8 strip
    set_bind(4, 1, 3); step("R2 idle");
    set_req(0, 3, 0, 'h1000, 0); step("R8 strip to legacy egress");
    set_req(0, 2, 0, 'h1000, 0); step("R8 no strip aware egress");
    // R9 plane 0 bind ignored, out-of-range port ignored
    set_bind(3, 1, 0); step("R9 plane0 bind");
    set_req(3, 2, 0, 'h1000, 0); step("R9 binding kept");
    set_bind(6, 1, 2); step("R9 bad port bind");
    set_req(0, 3, 0, 'h1000, 0); step("R9 after bad bind");
    // R10 bad egress port ignored
    set_tbl(3, 1, 3, 0, 0, 7, 'h1000, 'h1FFF); step("R10 bad port write");
    set_req(0, 3, 0, 'h1000, 0); step("R10 entry kept");
    // R12 removal and R9 unbind
    set_tbl(0, 0, 2, 0, 0, 1, 'h1000, 'h1FFF); step("R12 remove");
    set_req(0, 2, 0, 'h1000, 0); step("R12 falls through");
    set_bind(3, 0, 0); step("R9 unbind");
    set_req(3, 2, 0, 'h1000, 0); step("R9 unbound uses req plane");

    // random mix
    for (int n = 0; n < 3000; n++) begin
      if ($urandom_range(0, 3) == 0) begin
        longint b = longint'($urandom_range(0, 7)) * 'h1000;
        set_tbl($urandom_range(0, N-1), $urandom_range(0, 5) != 0,
                $urandom_range(0, 3), $urandom_range(0, 1),
                'h0100 + $urandom_range(0, 3), $urandom_range(0, 7),
                b, b + $urandom_range(0, 3) * 'h800 + 'h7FF);
      end
      if ($urandom_range(0, 7) == 0)
        set_bind($urandom_range(0, 7), $urandom_range(0, 1), $urandom_range(0, 3));
      if ($urandom_range(0, 4) != 0)
        set_req($urandom_range(0, 7), $urandom_range(0, 3),
                'h0100 + $urandom_range(0, 3),
                longint'($urandom_range(0, 'h9FFF)), $urandom_range(0, 1));
      step("R3 R4 R5 R8 random");
    end

    finish_run();
  end
endmodule